// File: doc/BRIEF.md
# Bank-Interleaved SDRAM Burst Command Scheduler

This block takes burst requests one at a time and turns them into a command and data stream for a single 16-bit, four-bank SDRAM device. A request names a bank, a row and a starting column. It also gives a direction, four 16-bit data beats packed into one word, and a two-bit byte mask for each beat. Every read and write goes out with auto-precharge set, so the scheduler never issues an explicit close command. Each request becomes an activate, followed two cycles later by a read or write command. The write data beats start on the same cycle as that command.

The gain comes from overlap. A four-beat burst keeps the command lines idle in its middle cycles. When the next request targets a different bank and keeps the same direction, the scheduler places that request's activate four cycles after the previous one. The new read or write then follows directly after the last beat of the previous burst, and the data bus carries no gap. Two cases wait longer. A request to the same bank waits until auto-precharge and the precharge time have both passed. A change of direction waits until the current burst has completely finished.

The request port uses a valid/ready handshake. The scheduler takes a request only in the cycle that lets its activate appear on the next clock, so `req_ready` depends on the bank and direction presented.

Top module: `sdram_interleave_sched`

## Requirements
- R1: While reset is asserted, the command lines show deselect ({cs_n,ras_n,cas_n,we_n} = 4'b1111), `sd_dq_oe` is 0, `sd_dqm` is 2'b11, and `req_ready` is 1 because no earlier request constrains the next one.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both high) appears after that edge as an activate: {cs_n,ras_n,cas_n,we_n} = 4'b0011, `sd_ba` equal to the request bank, and `sd_addr` equal to the row. No accepted request is ever dropped.
- R3: Two cycles after the activate, the column command appears. It is write 4'b0100 or read 4'b0101, with the same bank, `sd_addr[10]` = 1 (auto-precharge), `sd_addr[9:0]` equal to the column, and `sd_addr[12:11]` = 0.
- R4: Beat k (k = 0..3) is presented k cycles after the column command. `sd_dqm` carries mask bits [2k+1:2k] for both directions. For a write, `sd_dq_oe` is 1 and `sd_dq` carries data bits [16k+15:16k]. For a read, `sd_dq_oe` is 0 and `sd_dq` is 0.
- R5: From the first edge after reset, every cycle that carries neither an activate nor a column command carries NOP, 4'b0111.
- R6: When the next request targets a different bank and keeps the same direction, its activate comes 4 cycles after the previous activate (or as soon as it is presented, if later). Back-to-back bursts then drive beats on consecutive cycles with no gap.
- R7: When the next request targets the same bank as the previous one, whatever its row or direction, its activate comes at least 8 cycles after the previous activate. This allows 2 cycles to the column command, 4 cycles to the automatic close and 2 cycles of precharge time.
- R8: When the next request targets a different bank but reverses direction, its activate comes at least 6 cycles after the previous activate, which is the cycle after the last beat.
- R9: `req_ready` stays low until the spacing required for the presented request has been reached. In particular, it is low in every activate cycle.
- R10: In cycles with no beat, `sd_dq_oe` is 0, `sd_dq` is 0 and `sd_dqm` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Four beats, beat 0 in bits [15:0] |
| req_mask | input | 8 | Byte masks, beat k in bits [2k+1:2k] |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, or column with auto-precharge bit |
| sd_dq | output | 16 | Write data beat |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | 2 | Byte masks for the current beat |

## Verification
The assertions assume that every request presented is legal for the device: a bank below four, a column that fits in ten bits, and a burst that never wraps past the end of a row. They also assume that the request fields stay stable while `req_valid` is high and `req_ready` is low. The stimulus changes the fields only at falling edges, and only after an acceptance. It draws the bank, direction and idle spacing at random, and it mixes these draws with directed pairs that hit each spacing case: alternating banks, same bank, and reversed direction.

// File: rtl/sdram_interleave_sched.sv
module sdram_interleave_sched #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16,
  parameter int BURST  = 4,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int AP_BIT = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [BANK_W-1:0]            req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [COL_W-1:0]             req_col,
  input  logic                         req_write,
  input  logic [DQ_W*BURST-1:0]        req_wdata,
  input  logic [DQ_W/8*BURST-1:0]      req_mask,
  output logic                         sd_cs_n,
  output logic                         sd_ras_n,
  output logic                         sd_cas_n,
  output logic                         sd_we_n,
  output logic [BANK_W-1:0]            sd_ba,
  output logic [ROW_W-1:0]             sd_addr,
  output logic [DQ_W-1:0]              sd_dq,
  output logic                         sd_dq_oe,
  output logic [DQ_W/8-1:0]            sd_dqm
);
  localparam int MW       = DQ_W / 8;
  localparam int DW       = DQ_W * BURST;
  localparam int GAP_ALT  = BURST;
  localparam int GAP_TURN = T_RCD + BURST;
  localparam int GAP_SAME = T_RCD + BURST + T_RP;
  localparam int AGE_W    = $clog2(GAP_SAME + 1);
  localparam int CNT_W    = $clog2(BURST + 1);
  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_WR  = 4'b0100, C_RD  = 4'b0101;

  logic [AGE_W-1:0]  age, gap;
  logic              have_last, last_write, rw_due, accept, issue_rw;
  logic [BANK_W-1:0] last_bank, p_bank;
  logic [COL_W-1:0]  p_col;
  logic              p_write, sh_write;
  logic [DW-1:0]     p_data, sh_data;
  logic [MW*BURST-1:0] p_mask, sh_mask;
  logic [CNT_W-1:0]  sh_left;
  logic [3:0]        cmd;
  logic [ROW_W-1:0]  rw_addr;

  assign gap = (req_bank == last_bank)   ? AGE_W'(GAP_SAME) :
               (req_write != last_write) ? AGE_W'(GAP_TURN) : AGE_W'(GAP_ALT);
  assign req_ready = !have_last || (age >= gap - AGE_W'(1));
  assign accept    = req_valid && req_ready;
  assign issue_rw  = rw_due && (age == AGE_W'(T_RCD - 1));
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_comb begin
    rw_addr = '0;
    rw_addr[COL_W-1:0] = p_col;
    rw_addr[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '1;
      have_last <= 1'b0;
      last_bank <= '0;
      last_write <= 1'b0;
      rw_due <= 1'b0;
      p_bank <= '0;
      p_col <= '0;
      p_write <= 1'b0;
      p_data <= '0;
      p_mask <= '0;
    end else begin
      if (accept) age <= '0;
      else if (age != '1) age <= age + AGE_W'(1);
      if (accept) begin
        have_last <= 1'b1;
        last_bank <= req_bank;
        last_write <= req_write;
        rw_due <= 1'b1;
        p_bank <= req_bank;
        p_col <= req_col;
        p_write <= req_write;
        p_data <= req_wdata;
        p_mask <= req_mask;
      end else if (issue_rw) begin
        rw_due <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= C_DES;
      sd_ba <= '0;
      sd_addr <= '0;
    end else if (accept) begin
      cmd <= C_ACT;
      sd_ba <= req_bank;
      sd_addr <= req_row;
    end else if (issue_rw) begin
      cmd <= p_write ? C_WR : C_RD;
      sd_ba <= p_bank;
      sd_addr <= rw_addr;
    end else begin
      cmd <= C_NOP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_dq <= '0;
      sd_dqm <= '1;
      sd_dq_oe <= 1'b0;
      sh_data <= '0;
      sh_mask <= '0;
      sh_left <= '0;
      sh_write <= 1'b0;
    end else if (issue_rw) begin
      sd_dq <= p_write ? p_data[DQ_W-1:0] : '0;
      sd_dqm <= p_mask[MW-1:0];
      sd_dq_oe <= p_write;
      sh_data <= p_write ? (p_data >> DQ_W) : '0;
      sh_mask <= p_mask >> MW;
      sh_left <= CNT_W'(BURST - 1);
      sh_write <= p_write;
    end else if (sh_left != '0) begin
      sd_dq <= sh_data[DQ_W-1:0];
      sd_dqm <= sh_mask[MW-1:0];
      sd_dq_oe <= sh_write;
      sh_data <= sh_data >> DQ_W;
      sh_mask <= sh_mask >> MW;
      sh_left <= sh_left - CNT_W'(1);
    end else begin
      sd_dq <= '0;
      sd_dqm <= '1;
      sd_dq_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_interleave_sched_chk.sv
module sdram_interleave_sched_chk #(
  parameter int ROW_W  = 13,
  parameter int BURST  = 4,
  parameter int T_RCD  = 2,
  parameter int AP_BIT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe
);
  logic [3:0] c;
  logic       act, rw, wr;
  logic [3:0] since_act;

  assign c   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign act = (c == 4'b0011);
  assign rw  = (c[3:1] == 3'b010);
  assign wr  = (c == 4'b0100);

  always_ff @(posedge clk) begin
    if (!rst_n) since_act <= '1;
    else if (act) since_act <= 4'd1;
    else if (since_act != '1) since_act <= since_act + 4'd1;
  end

  p_accept_gives_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> act);
  p_rw_after_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> (since_act == 4'(T_RCD)));
  p_autoprecharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> sd_addr[AP_BIT]);
  p_oe_starts_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_dq_oe) |-> wr);
  p_act_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (since_act >= 4'(BURST)));
  p_busy_after_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !req_ready);
endmodule

bind sdram_interleave_sched sdram_interleave_sched_chk #(
  .ROW_W(ROW_W), .BURST(BURST), .T_RCD(T_RCD), .AP_BIT(AP_BIT)
) u_chk (.*);

// File: tb/sdram_interleave_sched_bench.sv
`timescale 1ns/1ps
module sdram_interleave_sched_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0] req_mask = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq;

  sdram_interleave_sched u_sdram_interleave_sched (.*);

  always #2 clk = ~clk;

  typedef struct { int cyc; logic [3:0] cmd; logic [1:0] ba; logic [12:0] addr; } cmd_t;
  typedef struct { int cyc; logic oe; logic [15:0] dq; logic [1:0] dqm; } beat_t;
  cmd_t cq[$];
  beat_t bq[$];

  int cyc = 0, checks = 0, fails = 0;
  bit mon_en = 1'b0, have = 1'b0, prev_w = 1'b0;
  int prev_acc = 0;
  logic [1:0] prev_bank = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] c;
    if (mon_en) begin
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (cq.size() > 0 && cq[0].cyc == cyc) begin
        chk(c == cq[0].cmd && sd_ba == cq[0].ba && sd_addr == cq[0].addr,
            (cq[0].cmd == 4'b0011) ? "R2" : "R3", "command",
            {45'd0, c, sd_ba, sd_addr}, {45'd0, cq[0].cmd, cq[0].ba, cq[0].addr});
        void'(cq.pop_front());
      end else begin
        chk(c == 4'b0111, "R5", "idle command", {60'd0, c}, 64'h7);
      end
      if (bq.size() > 0 && bq[0].cyc == cyc) begin
        chk(sd_dq_oe == bq[0].oe && sd_dq == bq[0].dq && sd_dqm == bq[0].dqm, "R4", "beat",
            {45'd0, sd_dq_oe, sd_dq, sd_dqm}, {45'd0, bq[0].oe, bq[0].dq, bq[0].dqm});
        void'(bq.pop_front());
      end else begin
        chk(!sd_dq_oe && sd_dq == 16'd0 && sd_dqm == 2'b11, "R10", "no-beat bus",
            {45'd0, sd_dq_oe, sd_dq, sd_dqm}, {45'd0, 1'b0, 16'd0, 2'b11});
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c,
                      input bit w, input logic [63:0] d, input logic [7:0] m);
    int present, acc, exp, gap;
    string tag;
    present = cyc;
    req_bank = b; req_row = r; req_col = c; req_write = w;
    req_wdata = d; req_mask = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    if (!have) begin
      exp = present + 1; tag = "R9";
    end else begin
      if (b == prev_bank) begin gap = 8; tag = "R7"; end
      else if (w != prev_w) begin gap = 6; tag = "R8"; end
      else begin gap = 4; tag = "R6"; end
      exp = (present + 1 > prev_acc + gap) ? present + 1 : prev_acc + gap;
    end
    chk(acc == exp, tag, "activate spacing (R9 ready timing)", 64'(acc), 64'(exp));
    cq.push_back('{acc, 4'b0011, b, r});
    cq.push_back('{acc + 2, w ? 4'b0100 : 4'b0101, b, {2'b00, 1'b1, c}});
    for (int k = 0; k < 4; k++)
      bq.push_back('{acc + 2 + k, w, w ? d[16*k +: 16] : 16'd0, m[2*k +: 2]});
    have = 1'b1; prev_acc = acc; prev_bank = b; prev_w = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    bit [31:0] r0, r1, r2;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111 && !sd_dq_oe && sd_dqm == 2'b11
        && req_ready, "R1", "reset state",
        {58'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, req_ready},
        {58'd0, 4'b1111, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    // R6: alternating banks, writes stream without gaps
    send(2'd0, 13'h0000, 10'h000, 1'b1, 64'h4444_3333_2222_1111, 8'h00);
    send(2'd1, 13'h0000, 10'h004, 1'b1, 64'h8888_7777_6666_5555, 8'h1B);
    // R7: same bank, other row
    send(2'd1, 13'h1ABC, 10'h3FC, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 8'hE4);
    // R8: other bank, direction reversed
    send(2'd2, 13'h0FFF, 10'h010, 1'b0, 64'h0, 8'h00);
    // R6: reads alternating
    send(2'd3, 13'h1000, 10'h020, 1'b0, 64'h0, 8'hFF);
    send(2'd0, 13'h0001, 10'h030, 1'b0, 64'h0, 8'h5A);
    // R7: same bank, direction reversed
    send(2'd0, 13'h0002, 10'h040, 1'b1, 64'h0123_4567_89AB_CDEF, 8'h0F);
    repeat (15) @(negedge clk);
    // R9: after idle, taken at once
    send(2'd0, 13'h0003, 10'h050, 1'b1, 64'hFFFF_0000_FFFF_0000, 8'hC3);
    for (int i = 0; i < 40; i++) begin
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      send(r0[1:0], r0[14:2], {r0[22:17], 4'b0000}, r0[23], {r1, r2}, r0[31:24]);
      if (r1[3:0] == 4'd0) repeat (r2[3:0]) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    chk(cq.size() == 0 && bq.size() == 0, "R2", "all scheduled commands seen",
        64'(cq.size() + bq.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule